// File: doc/BRIEF.md
# DDR2 Power-Up Command Sequencer

This block produces the start-up command stream that a DDR2 device needs before normal traffic can begin. A single-cycle `go` pulse starts a run. The block first captures the static timing settings: write recovery, CAS latency, burst code and whether a second chip select is fitted. It then sends a fixed list of twelve 32-bit command words to a memory controller's direct-command port. Each word is handed over on a valid/ready handshake. When the second chip is enabled, the same list is sent again with the chip-select field set to 1. A one-cycle `done` pulse marks the end of the run.

The block computes the mode-register and extended-mode-register payloads from the captured settings. The stream covers these steps in order: a NOP, a precharge of all banks, clearing the third and fourth mode registers, disabling DQS#, a DLL reset, two refreshes, the final mode register, and the off-chip-driver calibration default and exit writes. The DRAM model, the PHY and the refresh engine belong to the neighbouring logic.

Top module: `ddr2_init_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `cmd_valid`, `done` and `busy` are low.
- R2: Each command word is laid out as follows: bits 31:28 are zero, bits 27:24 hold the command code, bits 23:20 the chip select, bits 19:16 the bank, and bits 15:0 the address.
- R3: The command codes used are mode-register set 0, precharge-all 1, auto-refresh 5 and NOP 7. An extended mode register n (n = 1, 2, 3) is written as code 0 with bank n, and the extended registers 2 and 3 are written with address 0.
- R4: The mode-register payload is mr = ((wr-1) << 9) | (cas << 4) | burst, with burst code 2 for length 4 and 3 for length 8.
- R5: The extended payload is 0x400 (DQS# off). The DLL-reset write carries mr | 0x100, and the calibration-default write carries 0x400 | 0x380.
- R6: For each chip, the words run in this order: NOP, PALL, EMR2(0), EMR3(0), EMR1(0x400), MR(mr|0x100), PALL, REFA, REFA, MR(mr), EMR1(0x780), EMR1(0x400). The bank and address of every word other than a mode write are 0.
- R7: With `two_chips` high, the twelve-word list is repeated with chip select 1 after chip 0 has finished. With `two_chips` low, only chip 0 is sent, for 12 words in total.
- R8: A word with `cmd_valid` high and `cmd_ready` low is held unchanged. Within a run, `cmd_valid` stays high from the first word until the last word is accepted, and the next word appears in the cycle after an acceptance.
- R9: `done` is high for exactly one cycle, in the cycle after the last word is accepted, and `cmd_valid` is low in that cycle. Afterwards the block is idle.
- R10: A `go` pulse while `busy` is high, including the `done` cycle, does not restart or extend the run.
- R11: `wr_cycles`, `cas_lat`, `burst_code` and `two_chips` are captured on the accepted `go`. Changes to them during a run have no effect on that run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start pulse, taken only when idle |
| wr_cycles | input | 4 | Write recovery in clocks (2..8) |
| cas_lat | input | 3 | CAS latency |
| burst_code | input | 3 | Burst code (2 = BL4, 3 = BL8) |
| two_chips | input | 1 | Repeat the list for chip select 1 |
| cmd_valid | output | 1 | Command word valid |
| cmd_ready | input | 1 | Controller accepts the word |
| cmd_word | output | 32 | Direct-command word |
| busy | output | 1 | Run in progress, including the done cycle |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench sweeps write recovery, CAS latency, burst code and the chip count. This exposes errors in the mode payload's field placement: a shift or masking fault changes a different bit for each setting. Each sweep point is run under one of three ready patterns: always ready, alternate cycles, and one cycle in three. These separate a correct hold-until-accepted handshake from one that skips or repeats a word. Some runs pulse `go` in the middle of the run and again during `done`, and change the settings after start. These runs show whether a restart or a late-sampled setting leaks into the stream.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

    localparam int WORD_W  = 32;
    localparam int ADDR_W  = 16;
    localparam int FIELD_W = 4;
    localparam int WR_W    = 4;
    localparam int CAS_W   = 3;
    localparam int BL_W    = 3;
    localparam int STEPS   = 12;
    localparam int STEP_W  = $clog2(STEPS);

    localparam logic [ADDR_W-1:0] EMR_BASE   = 16'h0400;
    localparam logic [ADDR_W-1:0] DLL_RST    = 16'h0100;
    localparam logic [ADDR_W-1:0] OCD_DFLT   = 16'h0380;

    typedef enum logic [FIELD_W-1:0] {
        OP_MRS  = 4'd0,
        OP_PALL = 4'd1,
        OP_PRE  = 4'd2,
        OP_DPD  = 4'd3,
        OP_SREF = 4'd4,
        OP_REFA = 4'd5,
        OP_CKEL = 4'd6,
        OP_NOP  = 4'd7,
        OP_SRX  = 4'd8,
        OP_MRR  = 4'd9
    } dram_op_e;

    typedef struct packed {
        logic [FIELD_W-1:0] rsvd;
        dram_op_e           op;
        logic [FIELD_W-1:0] chip;
        logic [FIELD_W-1:0] bank;
        logic [ADDR_W-1:0]  addr;
    } dcmd_t;

    typedef struct packed {
        dram_op_e           op;
        logic [FIELD_W-1:0] bank;
        logic [ADDR_W-1:0]  addr;
    } step_cmd_t;

    typedef struct packed {
        logic [WR_W-1:0]  wr;
        logic [CAS_W-1:0] cas;
        logic [BL_W-1:0]  burst;
        logic             two;
    } seq_cfg_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_FINISH
    } seq_state_e;

    function automatic logic [ADDR_W-1:0] build_mr(input seq_cfg_t c);
        logic [ADDR_W-1:0] wm1;
        wm1 = ADDR_W'(c.wr) - ADDR_W'(1);
        return (wm1 << 9) | (ADDR_W'(c.cas) << 4) | ADDR_W'(c.burst);
    endfunction

    function automatic step_cmd_t mk_step(input dram_op_e op, input int bank,
                                          input logic [ADDR_W-1:0] addr);
        step_cmd_t s;
        s.op   = op;
        s.bank = FIELD_W'(bank);
        s.addr = addr;
        return s;
    endfunction

endpackage

// File: rtl/ddr2_mode_calc.sv
module ddr2_mode_calc
    import ddr2_init_pkg::*;
(
    input  seq_cfg_t          cfg,
    output logic [ADDR_W-1:0] mr_base,
    output logic [ADDR_W-1:0] emr_base
);
    always_comb begin
        mr_base  = build_mr(cfg);
        emr_base = EMR_BASE;
    end
endmodule

// File: rtl/ddr2_step_decode.sv
module ddr2_step_decode
    import ddr2_init_pkg::*;
(
    input  logic [STEP_W-1:0] step,
    input  logic [ADDR_W-1:0] mr_base,
    input  logic [ADDR_W-1:0] emr_base,
    output step_cmd_t         cmd
);
    always_comb begin
        unique case (step)
            STEP_W'(0):  cmd = mk_step(OP_NOP,  0, '0);
            STEP_W'(1):  cmd = mk_step(OP_PALL, 0, '0);
            STEP_W'(2):  cmd = mk_step(OP_MRS,  2, '0);
            STEP_W'(3):  cmd = mk_step(OP_MRS,  3, '0);
            STEP_W'(4):  cmd = mk_step(OP_MRS,  1, emr_base);
            STEP_W'(5):  cmd = mk_step(OP_MRS,  0, mr_base | DLL_RST);
            STEP_W'(6):  cmd = mk_step(OP_PALL, 0, '0);
            STEP_W'(7):  cmd = mk_step(OP_REFA, 0, '0);
            STEP_W'(8):  cmd = mk_step(OP_REFA, 0, '0);
            STEP_W'(9):  cmd = mk_step(OP_MRS,  0, mr_base);
            STEP_W'(10): cmd = mk_step(OP_MRS,  1, emr_base | OCD_DFLT);
            STEP_W'(11): cmd = mk_step(OP_MRS,  1, emr_base);
            default:     cmd = mk_step(OP_NOP,  0, '0);
        endcase
    end
endmodule

// File: rtl/ddr2_seq_ctrl.sv
module ddr2_seq_ctrl
    import ddr2_init_pkg::*;
#(
    parameter int MAX_CHIPS = 2,
    localparam int CHIP_W   = (MAX_CHIPS > 1) ? $clog2(MAX_CHIPS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  seq_cfg_t          cfg_in,
    input  logic              cmd_ready,
    output seq_cfg_t          cfg_q,
    output logic [STEP_W-1:0] step,
    output logic [CHIP_W-1:0] chip,
    output logic              cmd_valid,
    output logic              busy,
    output logic              done
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

    seq_state_e        state;
    logic [CHIP_W-1:0] chip_last;

    always_comb begin
        chip_last = cfg_q.two ? CHIP_W'(MAX_CHIPS - 1) : '0;
        cmd_valid = (state == SQ_ISSUE);
        done      = (state == SQ_FINISH);
        busy      = (state != SQ_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            step  <= '0;
            chip  <= '0;
            cfg_q <= '0;
        end else begin
            unique case (state)
                SQ_IDLE: begin
                    if (go) begin
                        state <= SQ_ISSUE;
                        step  <= '0;
                        chip  <= '0;
                        cfg_q <= cfg_in;
                    end
                end
                SQ_ISSUE: begin
                    if (cmd_ready) begin
                        if (step == LAST_STEP) begin
                            if (chip != chip_last) begin
                                chip <= chip + CHIP_W'(1);
                                step <= '0;
                            end else begin
                                state <= SQ_FINISH;
                            end
                        end else begin
                            step <= step + STEP_W'(1);
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int MAX_CHIPS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [WR_W-1:0]   wr_cycles,
    input  logic [CAS_W-1:0]  cas_lat,
    input  logic [BL_W-1:0]   burst_code,
    input  logic              two_chips,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [WORD_W-1:0] cmd_word,
    output logic              busy,
    output logic              done
);
    localparam int CHIP_W = (MAX_CHIPS > 1) ? $clog2(MAX_CHIPS) : 1;

    seq_cfg_t          cfg_in;
    seq_cfg_t          cfg_q;
    logic [STEP_W-1:0] step;
    logic [CHIP_W-1:0] chip;
    logic [ADDR_W-1:0] mr_base;
    logic [ADDR_W-1:0] emr_base;
    step_cmd_t         scmd;
    dcmd_t             word;

    always_comb begin
        cfg_in.wr    = wr_cycles;
        cfg_in.cas   = cas_lat;
        cfg_in.burst = burst_code;
        cfg_in.two   = two_chips;
    end

    ddr2_seq_ctrl #(.MAX_CHIPS(MAX_CHIPS)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .cfg_in    (cfg_in),
        .cmd_ready (cmd_ready),
        .cfg_q     (cfg_q),
        .step      (step),
        .chip      (chip),
        .cmd_valid (cmd_valid),
        .busy      (busy),
        .done      (done)
    );

    ddr2_mode_calc u_mode (
        .cfg      (cfg_q),
        .mr_base  (mr_base),
        .emr_base (emr_base)
    );

    ddr2_step_decode u_step (
        .step     (step),
        .mr_base  (mr_base),
        .emr_base (emr_base),
        .cmd      (scmd)
    );

    always_comb begin
        word.rsvd = '0;
        word.op   = scmd.op;
        word.chip = FIELD_W'(chip);
        word.bank = scmd.bank;
        word.addr = scmd.addr;
        cmd_word  = word;
    end
endmodule

// File: rtl/ddr2_init_seq_chk.sv
module ddr2_init_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        go,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic [31:0] cmd_word,
    input logic        busy,
    input logic        done
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!cmd_valid && !done && !busy));

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_word[31:28] == 4'd0));

    // R3
    legal_code_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_word[27:24] == 4'd0 || cmd_word[27:24] == 4'd1 ||
                       cmd_word[27:24] == 4'd5 || cmd_word[27:24] == 4'd7));

    // R8
    hold_word_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_word)));

    // R8
    valid_busy_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> busy);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !cmd_valid);

    // R10
    busy_go_chk: assert property (@(posedge clk) disable iff (rst)
        (done && go) |=> !busy);
endmodule

bind ddr2_init_seq ddr2_init_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_word  (cmd_word),
    .busy      (busy),
    .done      (done)
);

// File: tb/ddr2_init_seq_tb.sv
module ddr2_init_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        go = 1'b0;
    logic [3:0]  wr_cycles = 4'd3;
    logic [2:0]  cas_lat = 3'd4;
    logic [2:0]  burst_code = 3'd2;
    logic        two_chips = 1'b0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [31:0] cmd_word;
    logic        busy;
    logic        done;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    ddr2_init_seq u_dut (
        .clk        (clk),
        .rst        (rst),
        .go         (go),
        .wr_cycles  (wr_cycles),
        .cas_lat    (cas_lat),
        .burst_code (burst_code),
        .two_chips  (two_chips),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_word   (cmd_word),
        .busy       (busy),
        .done       (done)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input int chip, input int k, input int wr,
                                             input int cas, input int bl);
        int mr, emr, op, bank, a;
        mr  = (wr - 1) * 512 + cas * 16 + bl;
        emr = 1024;
        op = 0; bank = 0; a = 0;
        case (k)
            0:  op = 7;
            1:  op = 1;
            2:  bank = 2;
            3:  bank = 3;
            4:  begin bank = 1; a = emr; end
            5:  a = mr + 256;
            6:  op = 1;
            7:  op = 5;
            8:  op = 5;
            9:  a = mr;
            10: begin bank = 1; a = emr + 896; end
            default: begin bank = 1; a = emr; end
        endcase
        return 32'(op * (1 << 24) + chip * (1 << 20) + bank * (1 << 16) + a);
    endfunction

    function automatic bit ready_pat(input int mode, input int cyc);
        if (mode == 0) return 1'b1;
        if (mode == 1) return (cyc % 2) == 1;
        return (cyc % 3) == 2;
    endfunction

    task automatic run_seq(input int wr, input int cas, input int bl, input bit two,
                           input int rmode, input bit poke);
        int nexp = two ? 24 : 12;
        int got = 0;
        int cyc = 0;
        bit fin = 0;
        bit stall = 0;
        logic [31:0] held = '0;
        wr_cycles = 4'(wr); cas_lat = 3'(cas); burst_code = 3'(bl); two_chips = two;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        if (poke) begin
            // R11: settings changed after start must not matter
            wr_cycles = 4'd7; cas_lat = 3'd2; burst_code = 3'd3; two_chips = !two;
        end
        while (!fin && cyc < 300) begin
            bit r;
            r = ready_pat(rmode, cyc);
            cmd_ready = r;
            go = 1'b0;
            if (stall)
                check(cmd_valid && cmd_word == held, "R8 hold", cmd_word, held);
            if (done) begin
                check(got == nexp, "R9 done after last word", 32'(got), 32'(nexp));
                check(!cmd_valid, "R9 valid low at done", 32'(cmd_valid), 32'd0);
                fin = 1;
                go = poke;  // R10: go during the done cycle
            end else begin
                if (got > 0 && got < nexp)
                    check(cmd_valid, "R8 no gap", 32'(cmd_valid), 32'd1);
                if (cmd_valid && r) begin
                    int chp = got / 12;
                    int k = got % 12;
                    logic [31:0] e;
                    e = exp_word(chp, k, wr, cas, bl);
                    check(got < nexp, "R7 word count", 32'(got), 32'(nexp));
                    check(cmd_word[31:28] == 4'd0 && cmd_word[23:20] == 4'(chp),
                          "R2 fields", cmd_word, e);
                    if (chp == 1)                 check(cmd_word == e, "R7 chip1", cmd_word, e);
                    else if (k == 5 || k == 10)   check(cmd_word == e, "R5", cmd_word, e);
                    else if (k == 9)              check(cmd_word == e, "R4", cmd_word, e);
                    else if (k == 2 || k == 3)    check(cmd_word == e, "R3", cmd_word, e);
                    else                          check(cmd_word == e, "R6", cmd_word, e);
                    got++;
                end
                if (poke && cyc == 4) go = 1'b1;  // R10: go mid-run
            end
            stall = cmd_valid && !r;
            held  = cmd_word;
            cyc++;
            @(negedge clk);
        end
        go = 1'b0;
        check(fin, "R9 done seen", 32'(fin), 32'd1);
        check(!done && !cmd_valid && !busy, "R10 idle after done",
              {29'd0, done, cmd_valid, busy}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!cmd_valid && !done && !busy, "R1 in reset", {29'd0, cmd_valid, done, busy}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!cmd_valid && !done && !busy, "R1 after reset", {29'd0, cmd_valid, done, busy}, 32'd0);

        run_seq(3, 4, 2, 1'b0, 0, 1'b0);
        run_seq(3, 4, 2, 1'b1, 1, 1'b1);

        for (int wr = 2; wr <= 6; wr++)
            for (int cas = 3; cas <= 6; cas++)
                for (int bl = 2; bl <= 3; bl++)
                    for (int two = 0; two <= 1; two++)
                        run_seq(wr, cas, bl, two[0], (wr + cas + bl) % 3, wr == 4);

        // R1: reset during a run returns to idle
        cmd_ready = 1'b0;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(!cmd_valid && !busy, "R1 mid-run reset", {30'd0, cmd_valid, busy}, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule